// File: doc/BRIEF.md
# Serial Flash Software Command Engine

This block lets software drive raw commands to SPI-style serial flash devices. Software loads up to seven transmit bytes into a buffer, sets byte counts and a bank number in a control word, and sets a start bit. The engine selects one flash bank, shifts the transmit bytes out in SPI mode 0 and then clocks in the requested number of reply bytes. The reply bytes land in a receive buffer that software reads back. A second start bit runs a fixed status-read command. It sends opcode 0x05, captures one reply byte and places it in the status word. That command does not touch the receive buffer.

Two sticky flags report progress. One is set when a software transfer ends. The other is set by an external write-complete pulse. Each flag has its own enable bit. The single interrupt output is high whenever an enabled flag is set. The register port is a simple one-cycle write strobe with a combinational read.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Writing a control word with bit 7 (start) set while the engine is idle starts a transfer on the bank given by bits 13:12. Transmit bytes go out MSB first in SPI mode 0 (clock idles low, the device samples on the rising edge), taken in order from byte 0 of the buffer (address 2 bits 7:0) upward. Writing 0 to bit 7 starts nothing.
- R2: Bits 2:0 give the number of bytes sent and bits 6:4 the number of bytes received. During the receive phase the engine drives 0x00 on the data-out line. Received byte k is stored at bits 8k+7:8k of the receive buffer: address 4 holds bytes 0 to 3 and address 5 holds bytes 4 to 6. The receive buffer is cleared when a transfer starts.
- R3: Both counts are captured when the transfer starts. Control writes made during the transfer change the readable fields but not the byte counts of the running transfer.
- R4: Exactly one chip select (active low) is asserted. It goes low once per transfer and stays low from the first transmit bit through the last receive bit. The serial clock is low whenever no chip select is active.
- R5: When a transfer ends, hardware clears control bit 7 and sets the transfer-finished flag (status bit 0).
- R6: Writing control bit 10 while idle sends opcode 0x05 to the selected bank and reads one byte into status bits 15:8. Hardware then clears bit 10. This command leaves the transfer-finished flag and the receive buffer unchanged.
- R7: A one-cycle pulse on `wc_evt` sets the write-complete flag (status bit 1).
- R8: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: `irq` is high when (status bit 0 AND control bit 8) OR (status bit 1 AND control bit 9).
- R10: Start requests (bit 7 or bit 10) written while a command is running are ignored. If both bits are written at once while idle, the transfer starts and the status-read request is dropped.
- R11: A transmit count of zero with a nonzero receive count performs a receive-only transfer. With both counts zero, no chip select is asserted, but the transfer still completes as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0 control, 1 status, 2/3 transmit buffer) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address (0 to 5) |
| rd_data | output | 32 | Combinational register read data |
| wc_evt | input | 1 | Write-complete event pulse |
| irq | output | 1 | Combined interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NBANK | Per-bank chip selects, active low |

## Verification
Transfers are run with several length mixes: three out and two in, transmit-only, receive-only, both counts zero, and the full seven-plus-seven. Together these separate a missing phase switch, an off-by-one byte count and a wrong buffer slot. A stray chip-select pulse, which would show up as a gap between phases, is caught by counting chip-select falls. The status-read command is run against a device model whose reply stream differs byte by byte, so a capture taken from the wrong position is visible. A mid-transfer control write with different counts and a new start shows whether the latched counts and the busy lockout hold. A simultaneous write of both start bits checks the priority rule.

// File: rtl/sfc_pkg.sv
// Shared constants and types for the serial flash command engine.
// Assumes 32-bit register words and at most seven bytes per phase.
package sfc_pkg;
    localparam int LEN_W     = 3;
    localparam int MAX_BYTES = (1 << LEN_W) - 1;
    localparam int BUF_W     = MAX_BYTES * 8;

    localparam logic [7:0] OP_RDSR = 8'h05;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_TXLO = 3'd2;
    localparam logic [2:0] A_TXHI = 3'd3;
    localparam logic [2:0] A_RXLO = 3'd4;
    localparam logic [2:0] A_RXHI = 3'd5;

    localparam int CB_TXL  = 0;
    localparam int CB_RXL  = 4;
    localparam int CB_SEND = 7;
    localparam int CB_TFIE = 8;
    localparam int CB_WCIE = 9;
    localparam int CB_RSR  = 10;
    localparam int CB_BANK = 12;

    typedef enum logic [1:0] {SQ_IDLE, SQ_TX, SQ_RX, SQ_FIN} seq_st_t;
endpackage

// File: rtl/sfc_shift.sv
// SPI mode-0 byte shifter: moves one byte out MSB first while sampling one
// byte in. The clock idles low and each half period lasts HALF clk cycles.
// Assumes go is only raised while busy is low.
module sfc_shift #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic       busy,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sr_tx;
    logic [7:0]    sr_rx;
    logic          active;

    // Bit timing: toggle the clock every HALF cycles, sample on the rise, shift on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            bitn   <= '0;
            sr_tx  <= '0;
            sr_rx  <= '0;
            active <= 1'b0;
            sck    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                sck    <= 1'b0;
                cnt    <= '0;
                bitn   <= '0;
                sr_tx  <= tx_byte;
            end else if (active) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        sr_rx <= {sr_rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            sr_tx <= {sr_tx[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign mosi    = sr_tx[7];
    assign busy    = active;
    assign rx_byte = sr_rx;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sck); // R4
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sck && $past(sck))); // R1
endmodule

// File: rtl/sfc_seq.sv
// Byte sequencer: on a start pulse it captures the counts and bank, runs the
// transmit phase and then the receive phase, holding one chip select low
// throughout, and then reports completion. Assumes one shifter byte in flight
// at a time and start pulses only while idle.
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_xfer,
    input  logic                start_rsr,
    input  logic [LEN_W-1:0]    tx_len,
    input  logic [LEN_W-1:0]    rx_len,
    input  logic [BANK_W-1:0]   bank,
    input  logic [BUF_W-1:0]    tx_buf,
    input  logic                sh_done,
    input  logic [7:0]          sh_rx,
    output logic                sh_go,
    output logic [7:0]          sh_byte,
    output logic [NBANK-1:0]    cs_n,
    output logic                rx_we,
    output logic                rx_clr,
    output logic [LEN_W-1:0]    rx_idx,
    output logic [7:0]          rx_data,
    output logic                xfer_done,
    output logic                rsr_done,
    output logic [7:0]          stat_byte
);
    seq_st_t             st;
    logic                is_rsr;
    logic                inflight;
    logic [LEN_W-1:0]    tx_n;
    logic [LEN_W-1:0]    rx_n;
    logic [LEN_W-1:0]    idx;
    logic [BANK_W-1:0]   bank_q;
    logic                sel;

    // Phase control: issue bytes one at a time and route replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            is_rsr    <= 1'b0;
            inflight  <= 1'b0;
            tx_n      <= '0;
            rx_n      <= '0;
            idx       <= '0;
            bank_q    <= '0;
            sh_go     <= 1'b0;
            sh_byte   <= '0;
            rx_we     <= 1'b0;
            rx_clr    <= 1'b0;
            rx_idx    <= '0;
            rx_data   <= '0;
            xfer_done <= 1'b0;
            rsr_done  <= 1'b0;
            stat_byte <= '0;
        end else begin
            sh_go     <= 1'b0;
            rx_we     <= 1'b0;
            rx_clr    <= 1'b0;
            xfer_done <= 1'b0;
            rsr_done  <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    idx      <= '0;
                    inflight <= 1'b0;
                    if (start_xfer) begin
                        is_rsr <= 1'b0;
                        tx_n   <= tx_len;
                        rx_n   <= rx_len;
                        bank_q <= bank;
                        rx_clr <= 1'b1;
                        if (tx_len != '0)      st <= SQ_TX;
                        else if (rx_len != '0) st <= SQ_RX;
                        else                   st <= SQ_FIN;
                    end else if (start_rsr) begin
                        is_rsr <= 1'b1;
                        tx_n   <= LEN_W'(1);
                        rx_n   <= LEN_W'(1);
                        bank_q <= bank;
                        st     <= SQ_TX;
                    end
                end
                SQ_TX: begin
                    if (!inflight) begin
                        sh_go    <= 1'b1;
                        sh_byte  <= is_rsr ? OP_RDSR : tx_buf[int'(idx)*8 +: 8];
                        inflight <= 1'b1;
                    end else if (sh_done) begin
                        inflight <= 1'b0;
                        if (idx == tx_n - 1'b1) begin
                            idx <= '0;
                            st  <= (rx_n != '0) ? SQ_RX : SQ_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                SQ_RX: begin
                    if (!inflight) begin
                        sh_go    <= 1'b1;
                        sh_byte  <= 8'h00;
                        inflight <= 1'b1;
                    end else if (sh_done) begin
                        inflight <= 1'b0;
                        if (is_rsr) begin
                            stat_byte <= sh_rx;
                        end else begin
                            rx_we   <= 1'b1;
                            rx_idx  <= idx;
                            rx_data <= sh_rx;
                        end
                        if (idx == rx_n - 1'b1) st <= SQ_FIN;
                        else                    idx <= idx + 1'b1;
                    end
                end
                default: begin
                    st <= SQ_IDLE;
                    if (is_rsr) rsr_done  <= 1'b1;
                    else        xfer_done <= 1'b1;
                end
            endcase
        end
    end

    assign sel = (st == SQ_TX) || (st == SQ_RX);

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign cs_n[b] = !(sel && (bank_q == BANK_W'(b)));
    end

    AST_COUNTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SQ_IDLE && $past(st) != SQ_IDLE) |-> ($stable(tx_n) && $stable(rx_n))); // R3
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_xfer || start_rsr) |-> (st == SQ_IDLE)); // R10
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R4
    AST_DESELECT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || rsr_done) |-> (&cs_n)); // R4
endmodule

// File: rtl/sfc_regs.sv
// Register file: control word with self-clearing start bits, write-one-to-clear
// status flags, transmit and receive buffers, and the interrupt combine.
// Assumes the sequencer raises xfer_done/rsr_done only after a start pulse.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [2:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic               wc_evt,
    input  logic               xfer_done,
    input  logic               rsr_done,
    input  logic [7:0]         stat_in,
    input  logic               rx_we,
    input  logic               rx_clr,
    input  logic [LEN_W-1:0]   rx_idx,
    input  logic [7:0]         rx_data,
    output logic               irq,
    output logic               start_xfer,
    output logic               start_rsr,
    output logic [LEN_W-1:0]   tx_len,
    output logic [LEN_W-1:0]   rx_len,
    output logic [BANK_W-1:0]  bank,
    output logic [BUF_W-1:0]   tx_buf
);
    logic             send_q;
    logic             rsr_q;
    logic             tfie;
    logic             wcie;
    logic             tff;
    logic             wcf;
    logic [7:0]       stat_q;
    logic [BUF_W-1:0] rx_buf;
    logic             busy;
    logic             ctrl_wr;
    logic             stat_wr;

    assign busy    = send_q | rsr_q;
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign stat_wr = wr_en && (wr_addr == A_STAT);

    // Control word: plain fields, start bits set only while idle, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_q     <= 1'b0;
            rsr_q      <= 1'b0;
            tfie       <= 1'b0;
            wcie       <= 1'b0;
            tx_len     <= '0;
            rx_len     <= '0;
            bank       <= '0;
            start_xfer <= 1'b0;
            start_rsr  <= 1'b0;
        end else begin
            start_xfer <= 1'b0;
            start_rsr  <= 1'b0;
            if (ctrl_wr) begin
                tfie   <= wr_data[CB_TFIE];
                wcie   <= wr_data[CB_WCIE];
                tx_len <= wr_data[CB_TXL +: LEN_W];
                rx_len <= wr_data[CB_RXL +: LEN_W];
                bank   <= wr_data[CB_BANK +: BANK_W];
                if (!busy && wr_data[CB_SEND]) begin
                    send_q     <= 1'b1;
                    start_xfer <= 1'b1;
                end else if (!busy && wr_data[CB_RSR]) begin
                    rsr_q     <= 1'b1;
                    start_rsr <= 1'b1;
                end
            end
            if (xfer_done) send_q <= 1'b0;
            if (rsr_done)  rsr_q  <= 1'b0;
        end
    end

    // Status flags: event sets win over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tff    <= 1'b0;
            wcf    <= 1'b0;
            stat_q <= '0;
        end else begin
            tff <= xfer_done | (tff & !(stat_wr && wr_data[0]));
            wcf <= wc_evt    | (wcf & !(stat_wr && wr_data[1]));
            if (rsr_done) stat_q <= stat_in;
        end
    end

    // Data buffers: software fills transmit bytes, the sequencer fills receive bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf <= '0;
            rx_buf <= '0;
        end else begin
            if (wr_en && wr_addr == A_TXLO) tx_buf[31:0]       <= wr_data;
            if (wr_en && wr_addr == A_TXHI) tx_buf[BUF_W-1:32] <= wr_data[BUF_W-33:0];
            if (rx_clr)     rx_buf <= '0;
            else if (rx_we) rx_buf[int'(rx_idx)*8 +: 8] <= rx_data;
        end
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[CB_TXL +: LEN_W]   = tx_len;
                rd_data[CB_RXL +: LEN_W]   = rx_len;
                rd_data[CB_SEND]           = send_q;
                rd_data[CB_TFIE]           = tfie;
                rd_data[CB_WCIE]           = wcie;
                rd_data[CB_RSR]            = rsr_q;
                rd_data[CB_BANK +: BANK_W] = bank;
            end
            A_STAT: rd_data = {16'h0, stat_q, 6'h0, wcf, tff};
            A_TXLO: rd_data = tx_buf[31:0];
            A_TXHI: rd_data = 32'(tx_buf[BUF_W-1:32]);
            A_RXLO: rd_data = rx_buf[31:0];
            A_RXHI: rd_data = 32'(rx_buf[BUF_W-1:32]);
            default: rd_data = '0;
        endcase
    end

    assign irq = (tff & tfie) | (wcf & wcie);

    AST_TFF_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tff) |-> $past(xfer_done)); // R5
    AST_SEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !send_q); // R5
    AST_RSR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rsr_done |=> !rsr_q); // R6
    AST_WCF_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcf) |-> $past(wc_evt)); // R7
endmodule

// File: rtl/sflash_cmd_engine.sv
// Top level of the serial flash software command engine: register file,
// byte sequencer and SPI mode-0 shifter. Assumes NBANK is 2 to 16.
module sflash_cmd_engine #(
    parameter int NBANK = 4,
    parameter int HALF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              wc_evt,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NBANK-1:0]  cs_n
);
    import sfc_pkg::*;
    localparam int BANK_W = $clog2(NBANK);

    logic                start_xfer;
    logic                start_rsr;
    logic [LEN_W-1:0]    tx_len;
    logic [LEN_W-1:0]    rx_len;
    logic [BANK_W-1:0]   bank;
    logic [BUF_W-1:0]    tx_buf;
    logic                xfer_done;
    logic                rsr_done;
    logic [7:0]          stat_byte;
    logic                rx_we;
    logic                rx_clr;
    logic [LEN_W-1:0]    rx_idx;
    logic [7:0]          rx_data;
    logic                sh_go;
    logic [7:0]          sh_byte;
    logic                sh_done;
    logic                sh_busy;
    logic [7:0]          sh_rx;

    sfc_regs #(.BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wc_evt(wc_evt),
        .xfer_done(xfer_done), .rsr_done(rsr_done), .stat_in(stat_byte),
        .rx_we(rx_we), .rx_clr(rx_clr), .rx_idx(rx_idx), .rx_data(rx_data),
        .irq(irq), .start_xfer(start_xfer), .start_rsr(start_rsr),
        .tx_len(tx_len), .rx_len(rx_len), .bank(bank), .tx_buf(tx_buf)
    );

    sfc_seq #(.NBANK(NBANK), .BANK_W(BANK_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_xfer(start_xfer), .start_rsr(start_rsr),
        .tx_len(tx_len), .rx_len(rx_len), .bank(bank), .tx_buf(tx_buf),
        .sh_done(sh_done), .sh_rx(sh_rx), .sh_go(sh_go), .sh_byte(sh_byte),
        .cs_n(cs_n), .rx_we(rx_we), .rx_clr(rx_clr), .rx_idx(rx_idx),
        .rx_data(rx_data), .xfer_done(xfer_done), .rsr_done(rsr_done),
        .stat_byte(stat_byte)
    );

    sfc_shift #(.HALF(HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_byte),
        .miso(miso), .sck(sck), .mosi(mosi), .done(sh_done),
        .busy(sh_busy), .rx_byte(sh_rx)
    );

    AST_CLOCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n)); // R4
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sh_go |-> !sh_busy); // R2
endmodule

// File: tb/sim_sflash_cmd_engine.sv
module sim_sflash_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wc_evt = 1'b0;
    logic        irq;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic [3:0]  cs_n;

    always #10 clk = ~clk;

    sflash_cmd_engine #(.NBANK(4), .HALF(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wc_evt(wc_evt), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct { logic [7:0] b; string tag; } exp_t;
    exp_t exp_q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Device model: reply stream and mosi capture, one driver per variable.
    logic [7:0] slv_out [16];
    logic       cs_act;
    int         nf = 0, nf0 = 0, nr = 0, nr0 = 0, cs_falls = 0;
    logic [3:0] last_sel = '0;
    logic [7:0] cap = '0;
    int         sbit;

    assign cs_act = ~&cs_n;
    assign sbit   = nf - nf0;
    assign miso   = slv_out[(sbit >> 3) & 15][7 - (sbit & 7)];

    always @(posedge cs_act) begin
        nf0      = nf;
        nr0      = nr;
        cs_falls = cs_falls + 1;
        last_sel = ~cs_n;
    end

    always @(negedge sck) nf = nf + 1;

    // Monitor: pop the expected byte as each mosi byte completes.
    always @(posedge sck) begin
        cap = {cap[6:0], mosi};
        nr  = nr + 1;
        if (((nr - nr0) % 8) == 0) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected byte", {24'h0, cap}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {24'h0, cap}, {24'h0, e.b});
            end
        end
    end

    task automatic push_exp(logic [7:0] b, string tag);
        exp_t e;
        e.b = b;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic seed_dev(logic [7:0] s);
        for (int k = 0; k < 16; k++) slv_out[k] = s + 8'(k);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd0, v);
            if (v[7] == 1'b0 && v[10] == 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int c0;
        seed_dev(8'h00);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(3'd0, v); chk("R5 reset ctrl", v, 32'h0);
        rd(3'd1, v); chk("R8 reset status", v, 32'h0);
        chk("R9 reset irq", {31'h0, irq}, 32'h0);
        chk("R4 reset cs", {28'h0, cs_n}, 32'hF);
        chk("R4 reset sck", {31'h0, sck}, 32'h0);

        // R1/R2/R3/R10: 3 out, 2 in on bank 1, with a mid-transfer rewrite
        wr(3'd2, 32'h4433_2211);
        seed_dev(8'hA0);
        push_exp(8'h11, "R1 tx byte0"); push_exp(8'h22, "R1 tx byte1");
        push_exp(8'h33, "R1 tx byte2");
        push_exp(8'h00, "R2 rx filler"); push_exp(8'h00, "R2 rx filler");
        c0 = cs_falls;
        wr(3'd0, 32'h0000_11A3);
        repeat (20) @(negedge clk);
        wr(3'd0, 32'h0000_1191);
        wait_idle();
        rd(3'd4, v); chk("R2 rx buffer", v, 32'h0000_A4A3);
        rd(3'd0, v); chk("R3 ctrl fields after rewrite, R5 send cleared", v, 32'h0000_1111);
        rd(3'd1, v); chk("R5 tff set", v, 32'h1);
        chk("R9 irq with tfie", {31'h0, irq}, 32'h1);
        chk("R4 one select per transfer", 32'(cs_falls - c0), 32'd1);
        chk("R4 bank 1 selected", {28'h0, last_sel}, 32'h2);
        chk("R3 R10 no extra bytes", 32'(exp_q.size()), 32'd0);

        // R8: write-one-to-clear
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R8 write zero keeps", v, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v); chk("R8 write one clears", v, 32'h0);
        chk("R9 irq low after clear", {31'h0, irq}, 32'h0);

        // R6: status read on bank 2
        seed_dev(8'h70);
        push_exp(8'h05, "R6 opcode"); push_exp(8'h00, "R6 filler");
        c0 = cs_falls;
        wr(3'd0, 32'h0000_2400);
        wait_idle();
        rd(3'd1, v); chk("R6 status byte, no tff", v, 32'h0000_7100);
        rd(3'd4, v); chk("R6 rx buffer untouched", v, 32'h0000_A4A3);
        rd(3'd0, v); chk("R6 rsr cleared", v, 32'h0000_2000);
        chk("R6 bank 2 selected", {28'h0, last_sel}, 32'h4);
        chk("R6 one select", 32'(cs_falls - c0), 32'd1);

        // R7/R9: write-complete event
        @(negedge clk); wc_evt = 1'b1; @(negedge clk); wc_evt = 1'b0;
        rd(3'd1, v); chk("R7 wcf set", v, 32'h0000_7102);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd0, 32'h0000_2200);
        @(negedge clk); chk("R9 irq with wcie", {31'h0, irq}, 32'h1);
        wr(3'd1, 32'h2);
        rd(3'd1, v); chk("R8 wcf cleared", v, 32'h0000_7100);
        chk("R9 irq low", {31'h0, irq}, 32'h0);

        // R11: receive-only on bank 0
        seed_dev(8'h30);
        push_exp(8'h00, "R11 filler"); push_exp(8'h00, "R11 filler");
        c0 = cs_falls;
        wr(3'd0, 32'h0000_00A0);
        wait_idle();
        rd(3'd4, v); chk("R11 receive-only data", v, 32'h0000_3130);
        chk("R11 one select", 32'(cs_falls - c0), 32'd1);
        chk("R11 bank 0", {28'h0, last_sel}, 32'h1);
        wr(3'd1, 32'h1);

        // R11: empty transfer
        c0 = cs_falls;
        wr(3'd0, 32'h0000_0080);
        wait_idle();
        chk("R11 empty no select", 32'(cs_falls - c0), 32'd0);
        rd(3'd1, v); chk("R11 empty sets tff", v, 32'h0000_7101);
        wr(3'd1, 32'h1);

        // R10: both start bits at once on bank 3
        seed_dev(8'h50);
        push_exp(8'h11, "R10 send wins");
        wr(3'd0, 32'h0000_3481);
        rd(3'd0, v); chk("R10 rsr dropped", {20'h0, v[11:0]} & 32'h480, 32'h080);
        wait_idle();
        rd(3'd1, v); chk("R10 status byte unchanged", v, 32'h0000_7101);
        chk("R10 no extra bytes", 32'(exp_q.size()), 32'd0);
        wr(3'd1, 32'h1);

        // R2 boundary: 7 out, 7 in on bank 1
        wr(3'd2, 32'h0403_0201);
        wr(3'd3, 32'h0007_0605);
        seed_dev(8'hC0);
        for (int k = 1; k <= 7; k++) push_exp(8'(k), "R2 max tx");
        for (int k = 0; k < 7; k++) push_exp(8'h00, "R2 max filler");
        wr(3'd0, 32'h0000_10F7);
        wait_idle();
        rd(3'd4, v); chk("R2 max rx low", v, 32'hCAC9_C8C7);
        rd(3'd5, v); chk("R2 max rx high", v, 32'h00CD_CCCB);
        chk("R2 all bytes seen", 32'(exp_q.size()), 32'd0);

        finish_run();
    end
endmodule